// File: doc/BRIEF.md
# Serial Flash Page-Program Sequencer

This block is the master side of a serial-flash write path. A client hands it one write request, made of a 24-bit start address and a byte count, and then supplies the data bytes through a FIFO-style valid/ready port. The sequencer cuts the request into program transactions that each stay inside one flash page. It writes every piece with a fixed three-transaction pattern: a write-enable, then a page-program frame carrying the address and data, then status reads repeated until the device reports that its internal write cycle has finished.

The SPI side is a mode-0 byte serializer with a programmable SCK half period. A separate timer watches chip select and holds it high for a minimum number of system clocks between any two transactions. The number of status reads per page is bounded by a run-time limit. When the limit is used up the request is abandoned and an error flag is raised. When the last piece completes, a one-cycle done pulse is given. The parameter LEN_W must be larger than PAGE_W.

Top module: `spi_prog_seq`

## Requirements
- R1: While reset is held: cs_n=1, sck=0, done=0, err=0, req_ready=1 and wr_ready=0.
- R2: Every page-program transaction is preceded by a chip-select period that carries exactly one byte, 0x06 (write enable).
- R3: A page-program transaction carries 0x02, then the piece's start address as three bytes (bits 23:16, 15:8, 7:0), then the piece's data bytes in the order they were accepted on the write port.
- R4: The data length of each piece equals min(bytes still to write, 2^PAGE_W − (address mod 2^PAGE_W)). Each piece starts where the previous one ended, so a piece never crosses a page boundary.
- R5: After each page program the block issues status-read transactions (0x05 followed by one read byte) and nothing else, until a read returns bit 0 (write in progress) equal to 0.
- R6: Between any two transactions cs_n stays high for at least CS_GAP system clocks.
- R7: SPI mode 0: sck is low whenever cs_n is high, mosi changes only while sck is low, and every byte goes out MSB first.
- R8: After the final piece's status read returns ready, done pulses high for exactly one cycle, and req_ready is high again. req_ready is high only while no request is in progress.
- R9: If poll_limit status reads after one page program all return busy, err goes high, done does not pulse, and the block returns to idle. err stays high until the next request is accepted, which clears it.
- R10: wr_ready is high only while chip select is active in the data phase, and exactly req_len bytes are consumed for a request that completes.
- R11: A request with req_len=0 produces a done pulse in the cycle after acceptance, with no SPI transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 24 | Flash start address of the request |
| req_len | input | LEN_W | Number of bytes to write |
| wr_valid | input | 1 | Data byte available |
| wr_ready | output | 1 | Data byte is taken this cycle when wr_valid is high |
| wr_data | input | 8 | Data byte |
| poll_limit | input | POLL_W | Maximum status reads per page before an error |
| done | output | 1 | One-cycle pulse: request fully written |
| err | output | 1 | Polling timed out on the last request |
| sck | output | 1 | SPI clock (mode 0) |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the flash |
| miso | input | 1 | SPI data from the flash |

## Verification
The bench builds the block with PAGE_W=4 (16-byte pages), SCK_HALF=1, CS_GAP=3, LEN_W=12 and POLL_W=8. With pages this small, every start offset in a page can be combined with lengths of one byte, exactly one page, one page plus one and several pages, so each split shape of the chunk arithmetic is reached in a short run. A flash model answers status reads busy for a chosen number of polls, and it stalls the write port on some requests. This covers the polling loop, the timeout at a small limit and the data-phase back-pressure.

// File: rtl/spq_pkg.sv
package spq_pkg;

  localparam int ADDR_W = 24;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_RDSR  = 8'h05;
  localparam logic [7:0] OP_DUMMY = 8'h00;
  localparam logic [7:0] WIP_MASK = 8'h01;

  typedef enum logic [3:0] {
    S_IDLE,
    S_WEN_WAIT,
    S_WEN_BYTE,
    S_PP_WAIT,
    S_PP_HDR,
    S_PP_DATA,
    S_POLL_WAIT,
    S_POLL_CMD,
    S_POLL_RD
  } spq_state_e;

endpackage

// File: rtl/spq_shifter.sv
module spq_shifter #(
  parameter int HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       active,
  output logic [7:0] rx,
  output logic       sck,
  output logic       mosi
);

  localparam int DW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sh;
  logic          tick;

  assign tick = (div == DW'(HALF - 1));
  assign mosi = sh[7];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      sh     <= '0;
      rx     <= '0;
      sck    <= 1'b0;
    end else if (!active) begin
      if (start) begin
        sh     <= tx;
        active <= 1'b1;
        div    <= '0;
        bitn   <= '0;
        sck    <= 1'b0;
      end
    end else begin
      div <= tick ? '0 : div + 1'b1;
      if (tick) begin
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
          end else begin
            bitn <= bitn + 1'b1;
            sh   <= {sh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R7: data line only moves while the clock is low
  p_mosi_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> $stable(mosi));

  // R3: a byte is never launched over one still in flight
  p_start_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !active);

endmodule

// File: rtl/spq_gap_timer.sv
module spq_gap_timer #(
  parameter int GAP = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  output logic gap_ok
);

  localparam int CW = $clog2(GAP + 2);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= CW'(GAP);
    else if (!cs_n)            cnt <= '0;
    else if (cnt < CW'(GAP))   cnt <= cnt + 1'b1;
  end

  assign gap_ok = cs_n && (cnt == CW'(GAP));

  // R6: counter saturates at the configured high time
  p_gap_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(GAP));

endmodule

// File: rtl/spq_chunker.sv
module spq_chunker #(
  parameter int PAGE_W = 8,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [23:0]       ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              advance,
  output logic [23:0]       cur_addr,
  output logic [LEN_W-1:0]  remain,
  output logic [PAGE_W:0]   chunk,
  output logic              last
);

  localparam int PAGE = 1 << PAGE_W;

  function automatic logic [PAGE_W:0] page_room(input logic [23:0] a);
    return (PAGE_W+1)'(PAGE) - {1'b0, a[PAGE_W-1:0]};
  endfunction

  function automatic logic [PAGE_W:0] chunk_len(input logic [23:0] a,
                                                input logic [LEN_W-1:0] r);
    logic [PAGE_W:0] room;
    room = page_room(a);
    if (r < LEN_W'(room)) return r[PAGE_W:0];
    return room;
  endfunction

  assign chunk = chunk_len(cur_addr, remain);
  assign last  = (remain == LEN_W'(chunk));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_addr <= '0;
      remain   <= '0;
    end else if (load) begin
      cur_addr <= ld_addr;
      remain   <= ld_len;
    end else if (advance) begin
      cur_addr <= cur_addr + 24'(chunk);
      remain   <= remain - LEN_W'(chunk);
    end
  end

  // R4: a piece fits between its start and the page end
  p_piece_in_page_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |-> (({1'b0, cur_addr[PAGE_W-1:0]} + chunk) <= (PAGE_W+1)'(PAGE)) && (chunk != '0));

  // R4: advancing never consumes more than is left
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance |-> (LEN_W'(chunk) <= remain));

endmodule

// File: rtl/spi_prog_seq.sv
module spi_prog_seq
  import spq_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int LEN_W    = 16,
  parameter int SCK_HALF = 2,
  parameter int CS_GAP   = 5,
  parameter int POLL_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [7:0]        wr_data,
  input  logic [POLL_W-1:0] poll_limit,
  output logic              done,
  output logic              err,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);

  spq_state_e        st;
  logic [1:0]        hdr_idx;
  logic [PAGE_W:0]   chunk_left;
  logic [POLL_W-1:0] poll_cnt;

  logic              sh_start;
  logic [7:0]        sh_tx;
  logic              sh_act;
  logic [7:0]        sh_rx;
  logic              gap_ok;

  logic [23:0]       cur_addr;
  logic [LEN_W-1:0]  remain;
  logic [PAGE_W:0]   chunk;
  logic              last;

  // named internal events
  logic              ev_accept;
  logic              ev_load;
  logic              ev_poll_end;
  logic              ev_wip;
  logic              ev_ready;
  logic              ev_exhaust;

  function automatic logic [7:0] hdr_byte(input logic [23:0] a, input logic [1:0] i);
    case (i)
      2'd0:    return a[23:16];
      2'd1:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction

  function automatic logic polls_used(input logic [POLL_W-1:0] cnt,
                                      input logic [POLL_W-1:0] lim);
    return ({1'b0, cnt} + 1'b1) >= {1'b0, lim};
  endfunction

  assign req_ready   = (st == S_IDLE);
  assign ev_accept   = req_ready && req_valid;
  assign ev_load     = ev_accept && (req_len != '0);
  assign ev_poll_end = (st == S_POLL_RD) && !sh_act;
  assign ev_wip      = (sh_rx & WIP_MASK) != 8'h00;
  assign ev_ready    = ev_poll_end && !ev_wip;
  assign ev_exhaust  = ev_poll_end && ev_wip && polls_used(poll_cnt, poll_limit);

  spq_shifter #(.HALF(SCK_HALF)) u_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (sh_start),
    .tx     (sh_tx),
    .miso   (miso),
    .active (sh_act),
    .rx     (sh_rx),
    .sck    (sck),
    .mosi   (mosi)
  );

  spq_gap_timer #(.GAP(CS_GAP)) u_gap (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .gap_ok (gap_ok)
  );

  spq_chunker #(.PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chunk (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ev_load),
    .ld_addr  (req_addr),
    .ld_len   (req_len),
    .advance  (ev_ready),
    .cur_addr (cur_addr),
    .remain   (remain),
    .chunk    (chunk),
    .last     (last)
  );

  always_comb begin
    sh_start = 1'b0;
    sh_tx    = 8'h00;
    wr_ready = 1'b0;
    case (st)
      S_WEN_WAIT: if (gap_ok) begin
        sh_start = 1'b1;
        sh_tx    = OP_WREN;
      end
      S_PP_WAIT: if (gap_ok) begin
        sh_start = 1'b1;
        sh_tx    = OP_PROG;
      end
      S_PP_HDR: if (!sh_act && hdr_idx != 2'd3) begin
        sh_start = 1'b1;
        sh_tx    = hdr_byte(cur_addr, hdr_idx);
      end
      S_PP_DATA: if (!sh_act && chunk_left != '0) begin
        wr_ready = 1'b1;
        sh_start = wr_valid;
        sh_tx    = wr_data;
      end
      S_POLL_WAIT: if (gap_ok) begin
        sh_start = 1'b1;
        sh_tx    = OP_RDSR;
      end
      S_POLL_CMD: if (!sh_act) begin
        sh_start = 1'b1;
        sh_tx    = OP_DUMMY;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cs_n       <= 1'b1;
      hdr_idx    <= '0;
      chunk_left <= '0;
      poll_cnt   <= '0;
      done       <= 1'b0;
      err        <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (ev_accept) begin
          err <= 1'b0;
          if (req_len == '0) done <= 1'b1;
          else               st   <= S_WEN_WAIT;
        end
        S_WEN_WAIT: if (gap_ok) begin
          cs_n <= 1'b0;
          st   <= S_WEN_BYTE;
        end
        S_WEN_BYTE: if (!sh_act) begin
          cs_n <= 1'b1;
          st   <= S_PP_WAIT;
        end
        S_PP_WAIT: if (gap_ok) begin
          cs_n       <= 1'b0;
          hdr_idx    <= '0;
          chunk_left <= chunk;
          st         <= S_PP_HDR;
        end
        S_PP_HDR: if (!sh_act) begin
          if (hdr_idx == 2'd3) st      <= S_PP_DATA;
          else                 hdr_idx <= hdr_idx + 1'b1;
        end
        S_PP_DATA: if (!sh_act) begin
          if (chunk_left == '0) begin
            cs_n     <= 1'b1;
            poll_cnt <= '0;
            st       <= S_POLL_WAIT;
          end else if (wr_valid) begin
            chunk_left <= chunk_left - 1'b1;
          end
        end
        S_POLL_WAIT: if (gap_ok) begin
          cs_n <= 1'b0;
          st   <= S_POLL_CMD;
        end
        S_POLL_CMD: if (!sh_act) st <= S_POLL_RD;
        S_POLL_RD: if (!sh_act) begin
          cs_n <= 1'b1;
          if (ev_ready) begin
            if (last) begin
              done <= 1'b1;
              st   <= S_IDLE;
            end else begin
              st <= S_WEN_WAIT;
            end
          end else if (ev_exhaust) begin
            err <= 1'b1;
            st  <= S_IDLE;
          end else begin
            poll_cnt <= poll_cnt + 1'b1;
            st       <= S_POLL_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R6: chip select only falls once the high-time timer has expired
  p_gap_before_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> $past(gap_ok));

  // R7: clock idles low while deselected
  p_sck_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck);

  // R8: completion is a single-cycle pulse
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9: completion and timeout never coincide
  p_done_not_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !err);

  // R10: data is fetched only inside a selected transaction
  p_fetch_selected_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> !cs_n);

  // R5: a busy status read is never followed by a new write enable
  p_busy_blocks_wren_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_poll_end && ev_wip) |=> (st != S_WEN_WAIT));

endmodule

// File: tb/sim_spi_prog_seq.sv
module sim_spi_prog_seq;

  localparam int PW   = 4;
  localparam int PAGE = 1 << PW;
  localparam int HALF = 1;
  localparam int GAP  = 3;
  localparam int LW   = 12;
  localparam int QW   = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [23:0]   req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [7:0]    wr_data;
  logic [QW-1:0] poll_limit = 8'd8;
  logic          done, err, sck, cs_n, mosi;
  logic          miso_r = 1'b0;

  always #2 clk = ~clk;

  spi_prog_seq #(.PAGE_W(PW), .LEN_W(LW), .SCK_HALF(HALF), .CS_GAP(GAP), .POLL_W(QW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_len(req_len), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .poll_limit(poll_limit), .done(done), .err(err),
    .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso_r)
  );

  int checks = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int r, input int k);
    return 8'(r * 29 + k * 7 + 3);
  endfunction

  // write-port source
  int  rqn = 0;
  int  fidx = 0;
  int  fbase = 0;
  int  cyc = 0;
  bit  stall = 0;
  assign wr_data = pat(rqn, fidx - fbase);
  always @(posedge clk) if (wr_valid && wr_ready) fidx <= fidx + 1;
  always @(negedge clk) begin
    cyc = cyc + 1;
    wr_valid = !(stall && (cyc % 3 == 0));
  end

  // flash model
  logic [7:0] rxb [0:63];
  int         nb = 0;
  int         bitc = 0;
  logic [7:0] shreg = '0;
  logic [7:0] stat = 8'h02;
  int         exp_st = 3;   // 0 wren, 1 program, 2 poll, 3 nothing expected
  logic [23:0] m_addr = '0;
  int         m_rem = 0, m_dbase = 0, busy_left = 0, busy_cfg = 0, polls = 0;
  bit         armed = 0;

  always @(negedge cs_n) begin
    nb = 0;
    bitc = 0;
    stat = (exp_st == 2 && busy_left > 0) ? 8'h03 : 8'h02;
  end

  always @(posedge sck) if (!cs_n) begin
    shreg = {shreg[6:0], mosi};
    bitc = bitc + 1;
    if (bitc % 8 == 0) begin
      if (nb < 64) rxb[nb] = shreg;
      nb = nb + 1;
    end
  end

  always @(negedge sck) if (!cs_n && bitc >= 8 && bitc < 16) miso_r = stat[15 - bitc];

  always @(posedge cs_n) if (armed) begin
    int n, room, en;
    case (exp_st)
      0: begin
        chk(nb == 1 && rxb[0] == 8'h06, "R2 write-enable frame", rxb[0], 6);
        exp_st = 1;
      end
      1: begin
        n = nb - 4;
        room = PAGE - int'(m_addr % PAGE);
        en = (m_rem < room) ? m_rem : room;
        chk(rxb[0] == 8'h02, "R3 program opcode", rxb[0], 2);
        chk({rxb[1], rxb[2], rxb[3]} == m_addr, "R3 R7 address bytes",
            int'({rxb[1], rxb[2], rxb[3]}), int'(m_addr));
        chk(n == en, "R4 piece length", n, en);
        for (int j = 0; j < n && j < 60; j++)
          chk(rxb[4 + j] == pat(rqn, m_dbase + j), "R3 R7 data byte", rxb[4 + j], pat(rqn, m_dbase + j));
        m_addr = m_addr + 24'(n);
        m_rem = m_rem - n;
        m_dbase = m_dbase + n;
        busy_left = busy_cfg;
        polls = 0;
        exp_st = 2;
      end
      2: begin
        chk(nb == 2 && rxb[0] == 8'h05, "R5 status read frame", rxb[0], 5);
        polls = polls + 1;
        if (busy_left > 0) busy_left = busy_left - 1;
        else exp_st = (m_rem > 0) ? 0 : 3;
      end
      default: chk(0, "R8 R11 unexpected transaction", nb, 0);
    endcase
  end

  // line monitors
  int hi = 1000;
  always @(negedge clk) if (rst_n) begin
    if (cs_n) begin
      if (sck) chk(0, "R7 sck idle low", 1, 0);
      hi = hi + 1;
    end else if (hi > 0) begin
      chk(hi >= GAP, "R6 deselect time", hi, GAP);
      hi = 0;
    end
    if (wr_ready && cs_n) chk(0, "R10 fetch outside data phase", 1, 0);
    if (req_ready && !cs_n) chk(0, "R8 ready while active", 1, 0);
  end

  task automatic run_req(input logic [23:0] a, input int len, input int bcfg,
                         input int lim, input bit stl, input bit expect_err);
    bit got_done, got_err;
    int n;
    @(negedge clk);
    rqn = rqn + 1;
    fbase = fidx;
    m_addr = a; m_rem = len; m_dbase = 0; busy_cfg = bcfg; polls = 0;
    exp_st = (len > 0) ? 0 : 3;
    armed = 1;
    stall = stl;
    req_addr = a; req_len = LW'(len); poll_limit = QW'(lim);
    chk(req_ready, "R8 ready before request", req_ready, 1);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!err, "R9 err cleared on accept", err, 0);
    got_done = 0; got_err = 0; n = 0;
    while (!got_done && !got_err && n < 30000) begin
      if (done) got_done = 1;
      if (err) got_err = 1;
      if (!(got_done || got_err)) begin
        @(negedge clk);
        n++;
      end
    end
    if (n >= 30000) chk(0, "R8 request watchdog", n, 0);
    if (len == 0) chk(got_done && n == 0, "R11 zero-length done next cycle", n, 0);
    if (expect_err) begin
      chk(got_err && !got_done, "R9 timeout flagged", got_err, 1);
      chk(polls == lim, "R9 status reads before timeout", polls, lim);
    end else begin
      chk(got_done && !got_err, "R8 done pulse", got_done, 1);
      chk(exp_st == 3, "R5 R8 all pieces polled", exp_st, 3);
      chk(fidx - fbase == len, "R10 bytes consumed", fidx - fbase, len);
    end
    @(negedge clk);
    chk(!done, "R8 single-cycle done", done, 0);
    chk(req_ready, "R8 ready after request", req_ready, 1);
    if (expect_err) chk(err, "R9 err held", err, 1);
    exp_st = 3;
  endtask

  initial begin
    int lens [4];
    lens[0] = 1; lens[1] = 16; lens[2] = 17; lens[3] = 40;
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n in reset", cs_n, 1);
    chk(sck == 1'b0, "R1 sck in reset", sck, 0);
    chk(!done && !err, "R1 flags in reset", done, 0);
    chk(req_ready && !wr_ready, "R1 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    for (int off = 0; off < 16; off++) begin
      for (int li = 0; li < 4; li++) begin
        run_req({8'hA5, 8'(off * 11 + li), 4'(li + off), 4'(off)}, lens[li],
                (off + li) % 3, 8, (li == 2) || (off % 4 == 1), 0);
      end
    end
    run_req(24'h000123, 0, 0, 8, 0, 0);
    run_req(24'h000040, 5, 50, 4, 0, 1);
    run_req(24'h00007E, 3, 1, 8, 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule